// File: doc/BRIEF.md
# Programmable Clock Output Generator

This block drives two clock outputs, each set up on its own. For every output, a configuration write picks one of five source clocks and a power-of-two prescaler from divide-by-1 to divide-by-64. The block runs in one system clock domain. Each source clock arrives as a one-cycle clock-enable strobe on `src_tick`. Each output is also a strobe: it gives one pulse for every 2^p strobes of the selected source.

Outputs are switched on through a write-one-to-set vector and switched off through a write-one-to-clear vector. `out_active` shows which outputs are switched on. `out_ready` goes high for an output once that output runs with its latest configuration. A configuration write clears the flag, and the flag sets again when the prescaler counter next wraps.

The block gives no glitch protection. Software is expected to switch an output off, reconfigure it, wait for `out_ready`, and then switch it on again. All pins are plain control and status pins with no handshake. A configuration write and the enable or disable vectors take effect on the next clock edge and cannot be back-pressured.

Top module: `prog_clk_out`

## Requirements
- R1: A configuration write (`cfg_wr` high) updates only the output numbered by `cfg_sel` (0 or 1). The other output's source, prescaler, counter and ready flag are unchanged.
- R2: `cfg_src` codes map to `src_tick` bits as follows: 0 = slow (bit 0), 1 = main (bit 1), 2 = PLL A (bit 2), 3 = UTMI PLL (bit 3), 4 = master (bit 4). Codes 5 to 7 select no source, so that output never pulses and its ready flag never sets.
- R3: With prescaler code p (0 to 6), an output pulses once per 2^p strobes of its selected source. Code 7 behaves as code 6 (divide-by-64).
- R4: The pulse on `clk_out[i]` is one cycle wide. It appears in the cycle after the source strobe that completes the count.
- R5: In any cycle, a 1 in bit i of `en_set` makes `out_active[i]` high from the next cycle. A 0 has no effect.
- R6: A 1 in bit i of `en_clr` makes `out_active[i]` low from the next cycle. A 0 has no effect. If set and clear are both 1 for the same bit, clear wins.
- R7: While `out_active[i]` is low, `clk_out[i]` stays low. The prescaler counter keeps running, so the pulses that follow a later enable keep the same phase.
- R8: A configuration write to output i clears `out_ready[i]` in the next cycle. The flag sets again in the cycle after the first counter wrap under the new setting.
- R9: A configuration write restarts that output's counter from zero and ignores any source strobe in the write cycle. The first pulse after the write therefore follows the 2^p-th strobe after the write cycle.
- R10: After reset, every output is inactive, low and not ready, with source code 0 and prescaler code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 5 | Clock-enable strobes of the five sources |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Output number targeted by the write |
| cfg_src | input | 3 | Source code written |
| cfg_pres | input | 3 | Prescaler code written |
| en_set | input | 2 | Write-one-to-set output enables |
| en_clr | input | 2 | Write-one-to-clear output enables |
| out_active | output | 2 | Output enable status |
| out_ready | output | 2 | Output runs with its programmed configuration |
| clk_out | output | 2 | Divided output strobes, low when disabled |

## Verification
The hardest case to reach is a disabled output whose prescaler keeps counting. The bench must show that pulses after re-enabling keep the old phase and do not restart. To get there, the stimulus disables a running output partway through a divide-by-4 count, feeds a few strobes, and enables it again partway through a later count. A cycle-accurate reference model then compares every output cycle. Strobes that arrive in the same cycle as a configuration write, and set and clear in the same cycle, are driven on purpose.

// File: rtl/pco_pkg.sv
package pco_pkg;
  localparam int NUM_SRC  = 5;
  localparam int SRC_W    = 3;
  localparam int PRES_W   = 3;
  localparam int PRES_MAX = 6;
  localparam int CNT_W    = PRES_MAX;

  typedef enum logic [SRC_W-1:0] {
    SRC_SLOW   = 3'd0,
    SRC_MAIN   = 3'd1,
    SRC_PLLA   = 3'd2,
    SRC_UTMI   = 3'd3,
    SRC_MASTER = 3'd4
  } src_e;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [PRES_W-1:0] pres;
  } out_cfg_t;
endpackage

// File: rtl/pco_enable_ctl.sv
module pco_enable_ctl #(
  parameter int NUM_OUT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-1:0] en_set,
  input  logic [NUM_OUT-1:0] en_clr,
  output logic [NUM_OUT-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n) active <= '0;
    else        active <= (active | en_set) & ~en_clr;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    |(en_set & ~en_clr) |=> ((~active & $past(en_set & ~en_clr)) == '0)); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    |en_clr |=> ((active & $past(en_clr)) == '0)); // R6
endmodule

// File: rtl/pco_divider.sv
module pco_divider
  import pco_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               cfg_wr,
  input  out_cfg_t           cfg_in,
  input  logic               enable,
  output logic               tick_out,
  output logic               ready
);
  out_cfg_t          cfg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic [PRES_W-1:0] pres_eff;
  logic              sel_tick;
  logic              wrap;

  always_comb begin
    pres_eff = (int'(cfg_q.pres) > PRES_MAX) ? PRES_W'(PRES_MAX) : cfg_q.pres;
    limit    = CNT_W'((32'd1 << pres_eff) - 32'd1);
    sel_tick = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cfg_q.src == SRC_W'(s)) sel_tick = src_tick[s];
    end
    wrap = sel_tick && (cnt_q == limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cnt_q    <= '0;
      ready    <= 1'b0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= enable & wrap & ~cfg_wr;
      if (cfg_wr) begin
        cfg_q <= cfg_in;
        cnt_q <= '0;
        ready <= 1'b0;
      end else if (sel_tick) begin
        if (wrap) begin
          cnt_q <= '0;
          ready <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !ready); // R8
  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick_out); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> (!tick_out || (limit == '0))); // R4
endmodule

// File: rtl/prog_clk_out.sv
module prog_clk_out
  import pco_pkg::*;
#(
  parameter int NUM_OUT = 2,
  parameter int SEL_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               cfg_wr,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [SRC_W-1:0]   cfg_src,
  input  logic [PRES_W-1:0]  cfg_pres,
  input  logic [NUM_OUT-1:0] en_set,
  input  logic [NUM_OUT-1:0] en_clr,
  output logic [NUM_OUT-1:0] out_active,
  output logic [NUM_OUT-1:0] out_ready,
  output logic [NUM_OUT-1:0] clk_out
);
  out_cfg_t wr_cfg;
  assign wr_cfg = '{src: cfg_src, pres: cfg_pres};

  pco_enable_ctl #(.NUM_OUT(NUM_OUT)) u_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_set (en_set),
    .en_clr (en_clr),
    .active (out_active)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic wr_this;
    assign wr_this = cfg_wr && (cfg_sel == SEL_W'(g));

    pco_divider u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .cfg_wr   (wr_this),
      .cfg_in   (wr_cfg),
      .enable   (out_active[g]),
      .tick_out (clk_out[g]),
      .ready    (out_ready[g])
    );
  end

  AST_OTHER_READY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == '0 && out_ready[NUM_OUT-1] && NUM_OUT > 1)
      |=> out_ready[NUM_OUT-1]); // R1
endmodule

// File: tb/prog_clk_out_bench.sv
module prog_clk_out_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] src_tick;
  logic       cfg_wr;
  logic [0:0] cfg_sel;
  logic [2:0] cfg_src, cfg_pres;
  logic [1:0] en_set, en_clr;
  logic [1:0] out_active, out_ready, clk_out;

  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prog_clk_out u_prog_clk_out (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_src(cfg_src), .cfg_pres(cfg_pres),
    .en_set(en_set), .en_clr(en_clr), .out_active(out_active),
    .out_ready(out_ready), .clk_out(clk_out)
  );

  // reference model state, built from the requirements
  int  m_cnt[2], m_src[2], m_pres[2];
  bit  m_rdy[2], m_act[2];
  logic [5:0] q_exp[$];
  string      q_tag[$];
  string      tag;
  logic [15:0] lfsr = 16'hACE1;

  task automatic step(input logic [4:0] t, input bit wr, input int sel,
                      input int src, input int pres,
                      input logic [1:0] set, input logic [1:0] clr);
    logic [1:0] eo;
    @(negedge clk);
    src_tick = t; cfg_wr = wr; cfg_sel = 1'(sel);
    cfg_src = 3'(src); cfg_pres = 3'(pres); en_set = set; en_clr = clr;
    for (int i = 0; i < 2; i++) begin
      bit wri, st;
      int ps, lim;
      wri = wr && (sel == i);
      ps  = (m_pres[i] > 6) ? 6 : m_pres[i];
      lim = (1 << ps) - 1;
      st  = (m_src[i] < 5) ? t[m_src[i]] : 1'b0;
      eo[i] = m_act[i] && st && (m_cnt[i] == lim) && !wri;
      if (wri) begin
        m_cnt[i] = 0; m_rdy[i] = 0; m_src[i] = src; m_pres[i] = pres;
      end else if (st) begin
        if (m_cnt[i] == lim) begin m_cnt[i] = 0; m_rdy[i] = 1; end
        else m_cnt[i]++;
      end
      if (set[i]) m_act[i] = 1;
      if (clr[i]) m_act[i] = 0;
    end
    @(posedge clk);
    q_exp.push_back({eo, m_rdy[1], m_rdy[0], m_act[1], m_act[0]});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input int mode);
    for (int k = 0; k < n; k++) begin
      logic [4:0] t;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      t = (mode == 1) ? 5'h1F : lfsr[4:0];
      step(t, 0, 0, 0, 0, 2'b00, 2'b00);
    end
  endtask

  task automatic cfg(input int sel, input int src, input int pres, input logic [4:0] t);
    step(t, 1, sel, src, pres, 2'b00, 2'b00);
  endtask

  // monitor: compares each cycle against the scoreboard
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [5:0] e, a;
      string tg;
      e = q_exp.pop_front();
      tg = q_tag.pop_front();
      a = {clk_out, out_ready, out_active};
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: {clk_out,ready,active} actual %b expected %b", tg, a, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_src[i] = 0; m_pres[i] = 0; m_rdy[i] = 0; m_act[i] = 0;
    end
    rst_n = 0; src_tick = 0; cfg_wr = 0; cfg_sel = 0; cfg_src = 0; cfg_pres = 0;
    en_set = 0; en_clr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    tests++;  // R10 reset state
    if ({clk_out, out_ready, out_active} !== 6'b0) begin
      fails++;
      $display("FAIL R10: actual %b expected %b", {clk_out, out_ready, out_active}, 6'b0);
    end

    tag = "R10";            idle(6, 1);
    tag = "R2 R3 R4 R5";    cfg(0, 1, 0, 5'h1F);
    step(5'h00, 0, 0, 0, 0, 2'b01, 2'b00); idle(40, 0);
    tag = "R1 R8";          cfg(1, 4, 3, 5'h10);
    step(5'h00, 0, 0, 0, 0, 2'b10, 2'b00); idle(80, 0);
    tag = "R5 R6 no-op";    step(5'h1F, 0, 0, 0, 0, 2'b00, 2'b00); idle(20, 0);
    tag = "R3 pres6";       cfg(0, 0, 6, 5'h00); idle(150, 1);
    tag = "R3 pres7";       cfg(0, 2, 7, 5'h00); idle(150, 1);
    tag = "R2 reserved";    cfg(0, 5, 0, 5'h1F); idle(40, 1);
    tag = "R6 clear wins";  step(5'h1F, 0, 0, 0, 0, 2'b01, 2'b01); idle(10, 1);
    tag = "R7";             cfg(0, 2, 2, 5'h00);
    step(5'h00, 0, 0, 0, 0, 2'b01, 2'b00); idle(9, 1);
    step(5'h04, 0, 0, 0, 0, 2'b00, 2'b01); idle(5, 0);
    step(5'h04, 0, 0, 0, 0, 2'b00, 2'b00);
    step(5'h04, 0, 0, 0, 0, 2'b01, 2'b00); idle(30, 0);
    tag = "R9";             cfg(0, 3, 1, 5'h1F); idle(20, 1);
    cfg(1, 3, 0, 5'h08); idle(10, 0);
    tag = "R1 R8 other";    cfg(0, 1, 2, 5'h1F); idle(12, 1);
    @(negedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule